// File: doc/BRIEF.md
# BCD Real-Time Clock Register Core

This block keeps calendar time as six BCD bytes (seconds, minutes, hours, day, month, two-digit year) and advances them on a once-per-second tick input. Firmware reaches the time, a status byte, two control bytes and a small bank of scratch bytes through a byte-wide register port with separate read and write strobes. Read data is registered and appears one cycle after the read strobe.

The time bytes are write-protected by a status bit that firmware must set before loading a new time and clear afterwards. Three sticky status flags (event, alarm, battery) are raised by input strobes and can only be dropped by writing zero, so a read-modify-write that writes back ones never loses a flag that arrived in between. An optional mode clears those flags automatically after the status byte is read. A clock-failed flag marks the time as untrustworthy after power-on until firmware loads a new seconds value. The hour byte supports both 24-hour and 12-hour (with PM bit) encodings.

Top module: `rtc_regcore`

## Requirements
- R1: After rst_n is released, the time reads seconds 0x00, minutes 0x00, hours 0x80, day 0x01, month 0x01, year 0x00; status reads 0x01; control, event and scratch bytes read 0x00.
- R2: Addresses 0x00 to 0x05 hold seconds, minutes, hours, day, month, year in that order. A write to one of them is stored only while status bit 4 (time-write enable) is 1; with that bit 0 the write leaves the byte unchanged.
- R3: Each cycle with tick_1hz high advances seconds in BCD from 0x59 to 0x00 with a carry into minutes (0x59 to 0x00), then hours, then day.
- R4: With hours bit 7 set (24-hour mode) the hour value in bits 5:0 runs 0x00 to 0x23 and carries into the day. With bit 7 clear (12-hour mode) bits 4:0 run 0x12, 0x01 ... 0x11; bit 5 (PM) toggles on the step from 0x11 to 0x12, and the day advances only when that step goes from PM to AM.
- R5: The day wraps to 0x01 after the month's last day (30 for months 04, 06, 09, 11; 31 for the others; February 29 when the year value is divisible by 4, else 28). Month wraps from 0x12 to 0x01 with a carry into the year, and the year wraps from 0x99 to 0x00.
- R6: Status is at 0x07. Bits 7 (auto-clear on read), 5 (oscillator-off, plain storage) and 4 (time-write enable) are read/write; bit 6 always reads 0.
- R7: Status bits 3 (event), 2 (alarm) and 1 (battery) are set by evt_strobe, alm_strobe and bat_strobe. Writing 0 to one of them clears it, writing 1 leaves it unchanged; a strobe in the same cycle as a clearing write leaves the bit set.
- R8: While status bit 7 is 1, a read of the status byte returns the flags as they are, and bits 3:1 clear on the following clock edge. While bit 7 is 0, reading does not change them.
- R9: Status bit 0 (clock failed) is set by reset and by the por input and is cleared only by a stored write to the seconds byte; por wins over a seconds write in the same cycle.
- R10: Address 0x08 (control), 0x09 (event setup), 0x12 and 0x13 (scratch) are plain read/write bytes; any unmapped address reads 0x00.
- R11: rdata is updated on the clock edge that samples rd high and holds its value while rd is low.
- R12: When a stored time write and a tick fall in the same cycle, the written byte takes the write data and the tick is dropped for all time bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por | input | 1 | Power-loss indication, sets the clock-failed flag |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| evt_strobe | input | 1 | Sets the event flag |
| alm_strobe | input | 1 | Sets the alarm flag |
| bat_strobe | input | 1 | Sets the battery flag |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |

## Verification
The checks on time rollover take for granted that every byte loaded into the time registers is a legal BCD value for its field, because the core stores whatever is written and its carry chain is defined only over legal values; the stimulus loads only legal calendar values and reaches every rollover from a time one tick before it. The flag checks assume the strobes are single-cycle pulses and that rd and wr are driven from the same side of the clock as the tick, which the bench respects by driving every input on the falling edge. The auto-clear check relies on no flag strobe arriving in the clearing cycle, and the bench spaces its strobes away from status reads accordingly.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_SEC  = 5'h00;
  localparam logic [ADDR_W-1:0] A_MIN  = 5'h01;
  localparam logic [ADDR_W-1:0] A_HOUR = 5'h02;
  localparam logic [ADDR_W-1:0] A_DAY  = 5'h03;
  localparam logic [ADDR_W-1:0] A_MON  = 5'h04;
  localparam logic [ADDR_W-1:0] A_YEAR = 5'h05;
  localparam logic [ADDR_W-1:0] A_STAT = 5'h07;
  localparam logic [ADDR_W-1:0] A_CTRL = 5'h08;
  localparam logic [ADDR_W-1:0] A_EVTC = 5'h09;
  localparam logic [ADDR_W-1:0] A_USR  = 5'h12;

  // status bit positions (decoded by firmware, so fixed)
  localparam int S_ARST = 7;
  localparam int S_OSC  = 5;
  localparam int S_WEN  = 4;
  localparam int S_EVT  = 3;
  localparam int S_ALM  = 2;
  localparam int S_BAT  = 1;
  localparam int S_FAIL = 0;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] day;
    logic [7:0] mon;
    logic [7:0] year;
  } rtc_time_t;

  localparam rtc_time_t TIME_RST = '{sec: 8'h00, min: 8'h00, hour: 8'h80,
                                     day: 8'h01, mon: 8'h01, year: 8'h00};

  // one BCD increment of a two-digit value
  function automatic logic [7:0] bcd_up(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // {carry, next}: wraps from last to first
  function automatic logic [8:0] wrap_up(input logic [7:0] v,
                                         input logic [7:0] last,
                                         input logic [7:0] first);
    if (v >= last) return {1'b1, first};
    return {1'b0, bcd_up(v)};
  endfunction

  // year divisible by 4: 10*t+o = 2*t+o (mod 4)
  function automatic logic is_leap(input logic [7:0] y);
    return y[4] ? (y[1:0] == 2'b10) : (y[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon,
                                          input logic [7:0] year);
    case (mon)
      8'h02:                      return is_leap(year) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // {carry into day, next hour byte}
  function automatic logic [8:0] hour_up(input logic [7:0] h);
    logic [8:0] r;
    logic [7:0] hv;
    logic       pm;
    if (h[7]) begin
      r = wrap_up({2'b00, h[5:0]}, 8'h23, 8'h00);
      return {r[8], 2'b10, r[5:0]};
    end
    hv = {3'b000, h[4:0]};
    pm = h[5];
    if (hv == 8'h11) return {pm, 2'b00, ~pm, 5'h12};
    if (hv >= 8'h12) return {1'b0, 2'b00, pm, 5'h01};
    hv = bcd_up(hv);
    return {1'b0, 2'b00, pm, hv[4:0]};
  endfunction

  function automatic rtc_time_t time_up(input rtc_time_t t);
    rtc_time_t  r;
    logic [8:0] c;
    r = t;
    c = wrap_up(t.sec, 8'h59, 8'h00);
    r.sec = c[7:0];
    if (c[8]) begin
      c = wrap_up(t.min, 8'h59, 8'h00);
      r.min = c[7:0];
      if (c[8]) begin
        c = hour_up(t.hour);
        r.hour = c[7:0];
        if (c[8]) begin
          c = wrap_up(t.day, last_day(t.mon, t.year), 8'h01);
          r.day = c[7:0];
          if (c[8]) begin
            c = wrap_up(t.mon, 8'h12, 8'h01);
            r.mon = c[7:0];
            if (c[8]) begin
              c = wrap_up(t.year, 8'h99, 8'h00);
              r.year = c[7:0];
            end
          end
        end
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/rtc_timekeep.sv
module rtc_timekeep
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic              wen,
  output rtc_time_t         tm,
  output logic              wr_ok,
  output logic              sec_wr_ok,
  output logic              tick_ok
);

  rtc_time_t tm_q;

  assign wr_ok     = wr && wen && (waddr <= A_YEAR);
  assign sec_wr_ok = wr_ok && (waddr == A_SEC);
  assign tick_ok   = tick && !wr_ok;
  assign tm        = tm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tm_q <= TIME_RST;
    end else if (wr_ok) begin
      case (waddr)
        A_SEC:   tm_q.sec  <= wdata;
        A_MIN:   tm_q.min  <= wdata;
        A_HOUR:  tm_q.hour <= wdata;
        A_DAY:   tm_q.day  <= wdata;
        A_MON:   tm_q.mon  <= wdata;
        default: tm_q.year <= wdata;
      endcase
    end else if (tick_ok) begin
      tm_q <= time_up(tm_q);
    end
  end

endmodule

// File: rtl/rtc_status.sv
module rtc_status
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       st_wr,
  input  logic       st_rd,
  input  logic [7:0] wdata,
  input  logic       por,
  input  logic       sec_wr_ok,
  input  logic       evt_set,
  input  logic       alm_set,
  input  logic       bat_set,
  output logic [7:0] stat,
  output logic       clr_fire
);

  logic       arst_q, osc_q, wen_q, fail_q;
  logic [2:0] flg_q, flg_d, set_v;
  logic       clr_pend_q;

  assign set_v = {evt_set, alm_set, bat_set};

  always_comb begin
    flg_d = flg_q;
    if (st_wr)    flg_d = flg_d & wdata[S_EVT:S_BAT];
    if (clr_fire) flg_d = '0;
    flg_d = flg_d | set_v;
  end

  assign clr_fire = clr_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arst_q     <= 1'b0;
      osc_q      <= 1'b0;
      wen_q      <= 1'b0;
      fail_q     <= 1'b1;
      flg_q      <= '0;
      clr_pend_q <= 1'b0;
    end else begin
      if (st_wr) begin
        arst_q <= wdata[S_ARST];
        osc_q  <= wdata[S_OSC];
        wen_q  <= wdata[S_WEN];
      end
      flg_q      <= flg_d;
      clr_pend_q <= st_rd && arst_q;
      if (por)            fail_q <= 1'b1;
      else if (sec_wr_ok) fail_q <= 1'b0;
    end
  end

  assign stat = {arst_q, 1'b0, osc_q, wen_q, flg_q, fail_q};

endmodule

// File: rtl/rtc_regcore.sv
module rtc_regcore
  import rtc_pkg::*;
#(
  parameter int N_USER = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por,
  input  logic              tick_1hz,
  input  logic              evt_strobe,
  input  logic              alm_strobe,
  input  logic              bat_strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr,
  input  logic              rd,
  output logic [7:0]        rdata
);

  localparam int USR_LAST = int'(A_USR) + N_USER - 1;

  rtc_time_t  tm_q;
  logic       wr_ok, sec_wr_ok, tick_ok, clr_fire;
  logic [7:0] stat;
  logic       st_wr, st_rd;
  logic [7:0] ctrl_q, evtc_q;
  logic [7:0] usr_q [N_USER];
  logic [7:0] rd_mux;
  logic [7:0] rdata_q;

  assign st_wr = wr && (addr == A_STAT);
  assign st_rd = rd && (addr == A_STAT);

  rtc_timekeep u_time (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_1hz),
    .wr       (wr),
    .waddr    (addr),
    .wdata    (wdata),
    .wen      (stat[S_WEN]),
    .tm       (tm_q),
    .wr_ok    (wr_ok),
    .sec_wr_ok(sec_wr_ok),
    .tick_ok  (tick_ok)
  );

  rtc_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_wr    (st_wr),
    .st_rd    (st_rd),
    .wdata    (wdata),
    .por      (por),
    .sec_wr_ok(sec_wr_ok),
    .evt_set  (evt_strobe),
    .alm_set  (alm_strobe),
    .bat_set  (bat_strobe),
    .stat     (stat),
    .clr_fire (clr_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      evtc_q <= '0;
    end else if (wr) begin
      if (addr == A_CTRL) ctrl_q <= wdata;
      if (addr == A_EVTC) evtc_q <= wdata;
    end
  end

  for (genvar g = 0; g < N_USER; g++) begin : g_usr
    localparam logic [ADDR_W-1:0] UA = ADDR_W'(int'(A_USR) + g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   usr_q[g] <= '0;
      else if (wr && (addr == UA))  usr_q[g] <= wdata;
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    case (addr)
      A_SEC:  rd_mux = tm_q.sec;
      A_MIN:  rd_mux = tm_q.min;
      A_HOUR: rd_mux = tm_q.hour;
      A_DAY:  rd_mux = tm_q.day;
      A_MON:  rd_mux = tm_q.mon;
      A_YEAR: rd_mux = tm_q.year;
      A_STAT: rd_mux = stat;
      A_CTRL: rd_mux = ctrl_q;
      A_EVTC: rd_mux = evtc_q;
      default: begin
        for (int k = 0; k < N_USER; k++)
          if (int'(addr) == int'(A_USR) + k) rd_mux = usr_q[k];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/rtc_regcore_chk.sv
module rtc_regcore_chk
  import rtc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              por,
  input logic              tick_1hz,
  input logic              evt_strobe,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        stat,
  input rtc_time_t         tm_q,
  input logic              sec_wr_ok,
  input logic              tick_ok,
  input logic              clr_fire
);

  // R9
  por_sets_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por |=> stat[S_FAIL]);

  // R9
  fail_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[S_FAIL]) |-> $past(sec_wr_ok));

  // R7
  evt_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[S_EVT]) |-> $past(evt_strobe));

  // R8
  autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fire && !evt_strobe) |=> !stat[S_EVT]);

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_ok && tm_q.sec == 8'h59) |=> (tm_q.sec == 8'h00));

  // R2
  locked_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr <= A_YEAR && !stat[S_WEN] && !tick_1hz) |=> $stable(tm_q));

endmodule

bind rtc_regcore rtc_regcore_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .por       (por),
  .tick_1hz  (tick_1hz),
  .evt_strobe(evt_strobe),
  .wr        (wr),
  .addr      (addr),
  .stat      (stat),
  .tm_q      (tm_q),
  .sec_wr_ok (sec_wr_ok),
  .tick_ok   (tick_ok),
  .clr_fire  (clr_fire)
);

// File: tb/sim_rtc_regcore.sv
`timescale 1ns/1ps
module sim_rtc_regcore;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por = 1'b0, tick_1hz = 1'b0;
  logic       evt_strobe = 1'b0, alm_strobe = 1'b0, bat_strobe = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_regcore u0 (
    .clk(clk), .rst_n(rst_n), .por(por), .tick_1hz(tick_1hz),
    .evt_strobe(evt_strobe), .alm_strobe(alm_strobe), .bat_strobe(bat_strobe),
    .addr(addr), .wdata(wdata), .wr(wr), .rd(rd), .rdata(rdata)
  );

  // {start sec,min,hour,day,mon,year, expected after one tick}
  localparam int NV = 13;
  localparam logic [95:0] VEC [NV] = '{
    {48'h5959A3311299, 48'h000080010100},  // R5 year wrap
    {48'h595911050620, 48'h000032050620},  // R4 11 AM -> 12 PM
    {48'h595931280223, 48'h000012010323},  // R4 11 PM -> 12 AM, R5 Feb 28
    {48'h595932100721, 48'h000021100721},  // R4 12 PM -> 1 PM
    {48'h595989150822, 48'h000090150822},  // R3 24h BCD hour carry
    {48'h5959A3280224, 48'h000080290224},  // R5 leap Feb 28
    {48'h5959A3290224, 48'h000080010324},  // R5 leap Feb 29
    {48'h5959A3300419, 48'h000080010519},  // R5 30-day month
    {48'h190080010100, 48'h200080010100},  // R3 seconds BCD digit
    {48'h5959A3280210, 48'h000080010310},  // R5 non-leap year 10
    {48'h5959A3280212, 48'h000080290212},  // R5 leap year 12
    {48'h595912030303, 48'h000001030303},  // R4 12 AM -> 1 AM
    {48'h590995310105, 48'h001095310105}   // R3 minute carry
  };

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  task automatic expect_reg(input string req, input string what,
                            input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd_reg(a, v);
    chk(req, what, v, exp);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_reg("R1", "sec",  5'h00, 8'h00);
    expect_reg("R1", "min",  5'h01, 8'h00);
    expect_reg("R1", "hour", 5'h02, 8'h80);
    expect_reg("R1", "day",  5'h03, 8'h01);
    expect_reg("R1", "mon",  5'h04, 8'h01);
    expect_reg("R1", "year", 5'h05, 8'h00);
    expect_reg("R1", "stat", 5'h07, 8'h01);
    expect_reg("R1", "ctrl", 5'h08, 8'h00);
    expect_reg("R1", "usr1", 5'h13, 8'h00);

    // R2 locked writes ignored
    wr_reg(5'h00, 8'h33);
    wr_reg(5'h03, 8'h15);
    expect_reg("R2", "sec locked", 5'h00, 8'h00);
    expect_reg("R2", "day locked", 5'h03, 8'h01);
    expect_reg("R9", "fail kept on locked write", 5'h07, 8'h01);

    // table of rollovers (R3 R4 R5)
    for (int i = 0; i < NV; i++) begin
      wr_reg(5'h07, 8'h10);
      for (int b = 0; b < 6; b++) wr_reg(5'(b), VEC[i][95 - 8*b -: 8]);
      wr_reg(5'h07, 8'h00);
      tick();
      for (int b = 0; b < 6; b++) begin
        rd_reg(5'(b), v);
        chk("R3 R4 R5", $sformatf("vector %0d byte %0d", i, b), v, VEC[i][47 - 8*b -: 8]);
      end
    end
    expect_reg("R9", "fail cleared by sec write", 5'h07, 8'h00);

    // R6 status control bits
    wr_reg(5'h07, 8'hF0);
    expect_reg("R6", "stat rw bits, bit6 zero", 5'h07, 8'hB0);
    wr_reg(5'h07, 8'h10);
    expect_reg("R6", "stat back", 5'h07, 8'h10);

    // R7 sticky flags
    @(negedge clk); evt_strobe = 1'b1; @(negedge clk); evt_strobe = 1'b0;
    @(negedge clk); alm_strobe = 1'b1; @(negedge clk); alm_strobe = 1'b0;
    @(negedge clk); bat_strobe = 1'b1; @(negedge clk); bat_strobe = 1'b0;
    expect_reg("R7", "flags set", 5'h07, 8'h1E);
    wr_reg(5'h07, 8'h1E);
    expect_reg("R7", "write ones keeps", 5'h07, 8'h1E);
    wr_reg(5'h07, 8'h16);
    expect_reg("R7", "write zero clears evt", 5'h07, 8'h16);
    @(negedge clk); addr = 5'h07; wdata = 8'h10; wr = 1'b1; alm_strobe = 1'b1;
    @(negedge clk); wr = 1'b0; alm_strobe = 1'b0;
    expect_reg("R7", "strobe beats clear", 5'h07, 8'h14);

    // R8 auto-clear on read
    wr_reg(5'h07, 8'h9E);
    @(negedge clk); evt_strobe = 1'b1; @(negedge clk); evt_strobe = 1'b0;
    expect_reg("R8", "flags returned on read", 5'h07, 8'h9C);
    expect_reg("R8", "flags cleared after read", 5'h07, 8'h90);
    wr_reg(5'h07, 8'h1E);
    @(negedge clk); bat_strobe = 1'b1; @(negedge clk); bat_strobe = 1'b0;
    expect_reg("R8", "no autoclear first", 5'h07, 8'h12);
    expect_reg("R8", "no autoclear second", 5'h07, 8'h12);

    // R9 clock-failed flag
    @(negedge clk); por = 1'b1; @(negedge clk); por = 1'b0;
    expect_reg("R9", "por sets fail", 5'h07, 8'h13);
    wr_reg(5'h01, 8'h07);
    expect_reg("R9", "min write keeps fail", 5'h07, 8'h13);
    wr_reg(5'h00, 8'h07);
    expect_reg("R9", "sec write clears fail", 5'h07, 8'h12);
    @(negedge clk); addr = 5'h00; wdata = 8'h08; wr = 1'b1; por = 1'b1;
    @(negedge clk); wr = 1'b0; por = 1'b0;
    expect_reg("R9", "por beats sec write", 5'h07, 8'h13);

    // R10 plain bytes
    wr_reg(5'h08, 8'h5A);
    wr_reg(5'h09, 8'hA5);
    wr_reg(5'h12, 8'h3C);
    wr_reg(5'h13, 8'hC3);
    wr_reg(5'h0F, 8'hFF);
    expect_reg("R10", "ctrl", 5'h08, 8'h5A);
    expect_reg("R10", "evt setup", 5'h09, 8'hA5);
    expect_reg("R10", "usr0", 5'h12, 8'h3C);
    expect_reg("R10", "usr1", 5'h13, 8'hC3);
    expect_reg("R10", "unmapped", 5'h0F, 8'h00);

    // R11 read data holds without rd
    expect_reg("R11", "read ctrl", 5'h08, 8'h5A);
    @(negedge clk); addr = 5'h09;
    @(negedge clk);
    chk("R11", "rdata holds", rdata, 8'h5A);

    // R12 write beats tick
    wr_reg(5'h00, 8'h10);
    wr_reg(5'h01, 8'h00);
    @(negedge clk); addr = 5'h01; wdata = 8'h05; wr = 1'b1; tick_1hz = 1'b1;
    @(negedge clk); wr = 1'b0; tick_1hz = 1'b0;
    expect_reg("R12", "sec not ticked", 5'h00, 8'h10);
    expect_reg("R12", "min written", 5'h01, 8'h05);
    wr_reg(5'h07, 8'h02);
    wr_reg(5'h00, 8'h44);
    tick();
    expect_reg("R2", "tick runs while locked", 5'h00, 8'h11);

    $display("test done: total=%0d bad=%0d", total, bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule